// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a single-cycle integer datapath that performs arithmetic with clamping instead of wraparound. An opcode selects one of ten functions: a plain wrapping add that still reports signed overflow, signed and unsigned add and subtract that clamp to the representable range, a signed doubling that clamps, and signed or unsigned saturation to a bit position chosen per operation. Each position-saturation function also has a dual-halfword form, in which the low and high 16-bit halves are each sign-extended, saturated on their own and packed back.

The result and a per-operation clamp indicator are combinational. A sticky flag records that at least one issued operation clamped since it was last cleared. An operation counts as issued when `valid_i` is high at a rising clock edge. The flag is cleared only by `clr_i` or by reset. A pipeline stage wraps the unit, reads the sticky flag when software asks for it, and pulses the clear input when software acknowledges it.

Top module: `sat_alu`

## Requirements
- R1: After reset is asserted (`rst_ni` low, asynchronous), `sticky_o` reads 0.
- R2: Op 1 (signed add): when both operands have the same sign bit and the sum's sign differs from `a_i`, `res_o` is 0x7FFFFFFF if `a_i` is non-negative, or 0x80000000 if `a_i` is negative, and `clamp_o` is 1. Otherwise `res_o` is the sum and `clamp_o` is 0.
- R3: Op 2 (signed subtract `a_i - b_i`): when the operand sign bits differ and the difference's sign differs from `a_i`, the result clamps as in R2 and `clamp_o` is 1. Otherwise `res_o` is the difference.
- R4: Op 3 (unsigned add) gives 0xFFFFFFFF with `clamp_o`=1 when the sum carries out. Op 4 (unsigned subtract) gives 0 with `clamp_o`=1 when `b_i > a_i`. Otherwise each gives the exact result.
- R5: Op 5 (signed doubling of `a_i`) gives 0x7FFFFFFF for `a_i` >= 0x40000000 and 0x80000000 for `a_i` <= 0xC0000000, signed in both cases, with `clamp_o`=1. Otherwise it gives `a_i << 1`.
- R6: Op 6 (signed saturation at position n = `pos_i`): with m = 2^n - 1, `a_i` > m gives m, `a_i` < -(m+1) gives ~m, each with `clamp_o`=1. Otherwise `a_i` passes through.
- R7: Op 7 (unsigned saturation at position n): a negative `a_i` gives 0, and a non-negative `a_i` above 2^n - 1 gives 2^n - 1, each with `clamp_o`=1. Otherwise `a_i` passes through.
- R8: Ops 8 and 9 apply R6 and R7 respectively to each sign-extended 16-bit half of `a_i` on its own. The low 16 bits of each lane result go to the matching half of `res_o`. `clamp_o` is 1 if either half clamps.
- R9: Op 0 (wrapping add) returns `a_i + b_i` modulo 2^32 and sets `clamp_o` under the signed-overflow condition of R2.
- R10: When `valid_i` and `clamp_o` are both 1 at a rising edge, `sticky_o` is 1 after that edge.
- R11: Without a clear, `sticky_o` keeps its value across an edge at which `valid_i` is 0 or `clamp_o` is 0. A clamping operation with `valid_i` low has no effect on it.
- R12: `clr_i` at an edge with no issued clamp makes `sticky_o` 0. An issued clamp in the same cycle wins, and `sticky_o` becomes 1.
- R13: Opcodes 10 to 15 give `res_o` = 0 and `clamp_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation is issued this cycle and may set the sticky flag |
| op_i | input | 4 | Function select, encodings as in the requirements |
| a_i | input | 32 | First operand, or the value to saturate |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Saturation bit position n |
| clr_i | input | 1 | Clears the sticky flag |
| res_o | output | 32 | Result |
| clamp_o | output | 1 | The current operation clamped (overflowed for op 0) |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
The hardest case to produce from the ports is a clear and an issued clamp landing on the same edge while the flag is already clear. Only then does the set-over-clear priority show in `sticky_o`. The stimulus first clears the flag and then issues a signed-add overflow with `clr_i` high in the same cycle. A second run issues a clamping operation with `valid_i` low. Dual-halfword vectors are chosen so that one half clamps upward and the other clamps downward or passes, which exposes lanes that are swapped or share a flag.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_WADD  = 4'd0,
    OP_SADD  = 4'd1,
    OP_SSUB  = 4'd2,
    OP_UADD  = 4'd3,
    OP_USUB  = 4'd4,
    OP_SDBL  = 4'd5,
    OP_SSAT  = 4'd6,
    OP_USAT  = 4'd7,
    OP_SSAT2 = 4'd8,
    OP_USAT2 = 4'd9
  } sat_op_e;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         uns_i,
  output logic [W-1:0] raw_o,
  output logic         s_ovf_o,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   ext;
  logic [W-1:0] clamp_val;

  always_comb begin
    if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i};
    else       ext = {1'b0, a_i} + {1'b0, b_i};
  end

  assign raw_o = ext[W-1:0];

  // sign-based overflow, shape depends on add vs subtract
  assign s_ovf_o = sub_i ? ((a_i[W-1] ^ b_i[W-1]) & (raw_o[W-1] ^ a_i[W-1]))
                         : (~(a_i[W-1] ^ b_i[W-1]) & (raw_o[W-1] ^ a_i[W-1]));

  // carry out on add, borrow on subtract
  assign ovf_o = uns_i ? ext[W] : s_ovf_o;

  always_comb begin
    if (uns_i)         clamp_val = sub_i ? '0 : '1;
    else if (a_i[W-1]) clamp_val = SMIN;
    else               clamp_val = SMAX;
  end

  assign res_o = ovf_o ? clamp_val : raw_o;
endmodule

// File: rtl/sat_dbl.sv
module sat_dbl #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] QTR  = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] NQTR = {2'b11, {(W-2){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic hi, lo;
  assign hi = $signed(a_i) >= $signed(QTR);
  assign lo = $signed(a_i) <= $signed(NQTR);

  assign ovf_o = hi | lo;

  always_comb begin
    if (hi)      res_o = SMAX;
    else if (lo) res_o = SMIN;
    else         res_o = {a_i[W-2:0], 1'b0};
  end
endmodule

// File: rtl/sat_clip.sv
module sat_clip #(
  parameter int unsigned W  = 32,
  parameter int unsigned OW = 32,
  parameter int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [PW-1:0] pos_i,
  input  logic          uns_i,
  output logic [OW-1:0] res_o,
  output logic          ovf_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] mask;
  logic [W-1:0] top;
  logic         top_pos, top_neg;
  logic         u_hi;

  assign mask    = (ONE << pos_i) - ONE;
  assign top     = W'($signed(val_i) >>> pos_i);
  assign top_pos = ~top[W-1] & (|top);
  assign top_neg = top[W-1] & ~(&top);
  assign u_hi    = ~val_i[W-1] & (val_i > mask);

  always_comb begin
    ovf_o = 1'b0;
    res_o = val_i[OW-1:0];
    if (uns_i) begin
      if (val_i[W-1]) begin
        ovf_o = 1'b1;
        res_o = '0;
      end else if (u_hi) begin
        ovf_o = 1'b1;
        res_o = mask[OW-1:0];
      end
    end else begin
      if (top_pos) begin
        ovf_o = 1'b1;
        res_o = mask[OW-1:0];
      end else if (top_neg) begin
        ovf_o = 1'b1;
        res_o = ~mask[OW-1:0];
      end
    end
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PW   = $clog2(WIDTH),
  localparam int unsigned HALF = WIDTH / LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [PW-1:0]    pos_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] res_o,
  output logic             clamp_o,
  output logic             sticky_o
);
  sat_op_e op;
  assign op = sat_op_e'(op_i);

  logic             as_sub, as_uns;
  logic [WIDTH-1:0] as_raw, as_res;
  logic             as_sovf, as_ovf;

  assign as_sub = (op == OP_SSUB) | (op == OP_USUB);
  assign as_uns = (op == OP_UADD) | (op == OP_USUB);

  sat_addsub #(.W(WIDTH)) i_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (as_sub),
    .uns_i  (as_uns),
    .raw_o  (as_raw),
    .s_ovf_o(as_sovf),
    .res_o  (as_res),
    .ovf_o  (as_ovf)
  );

  logic [WIDTH-1:0] dbl_res;
  logic             dbl_ovf;

  sat_dbl #(.W(WIDTH)) i_dbl (
    .a_i  (a_i),
    .res_o(dbl_res),
    .ovf_o(dbl_ovf)
  );

  logic [WIDTH-1:0] ws_res, wu_res;
  logic             ws_ovf, wu_ovf;

  sat_clip #(.W(WIDTH), .OW(WIDTH), .PW(PW)) i_clip_s (
    .val_i(a_i), .pos_i(pos_i), .uns_i(1'b0), .res_o(ws_res), .ovf_o(ws_ovf)
  );

  sat_clip #(.W(WIDTH), .OW(WIDTH), .PW(PW)) i_clip_u (
    .val_i(a_i), .pos_i(pos_i), .uns_i(1'b1), .res_o(wu_res), .ovf_o(wu_ovf)
  );

  logic [LANES-1:0][HALF-1:0] ls_res, lu_res;
  logic [LANES-1:0]           ls_ovf, lu_ovf;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WIDTH-1:0] lane_val;
    assign lane_val = {{(WIDTH-HALF){a_i[g*HALF+HALF-1]}}, a_i[g*HALF +: HALF]};

    sat_clip #(.W(WIDTH), .OW(HALF), .PW(PW)) i_lane_s (
      .val_i(lane_val), .pos_i(pos_i), .uns_i(1'b0),
      .res_o(ls_res[g]), .ovf_o(ls_ovf[g])
    );

    sat_clip #(.W(WIDTH), .OW(HALF), .PW(PW)) i_lane_u (
      .val_i(lane_val), .pos_i(pos_i), .uns_i(1'b1),
      .res_o(lu_res[g]), .ovf_o(lu_ovf[g])
    );
  end

  always_comb begin
    res_o   = '0;
    clamp_o = 1'b0;
    unique case (op)
      OP_WADD: begin
        res_o   = as_raw;
        clamp_o = as_sovf;
      end
      OP_SADD, OP_SSUB, OP_UADD, OP_USUB: begin
        res_o   = as_res;
        clamp_o = as_ovf;
      end
      OP_SDBL: begin
        res_o   = dbl_res;
        clamp_o = dbl_ovf;
      end
      OP_SSAT: begin
        res_o   = ws_res;
        clamp_o = ws_ovf;
      end
      OP_USAT: begin
        res_o   = wu_res;
        clamp_o = wu_ovf;
      end
      OP_SSAT2: begin
        res_o   = ls_res;
        clamp_o = |ls_ovf;
      end
      OP_USAT2: begin
        res_o   = lu_res;
        clamp_o = |lu_ovf;
      end
      default: begin
        res_o   = '0;
        clamp_o = 1'b0;
      end
    endcase
  end

  sat_sticky i_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (valid_i & clamp_o),
    .clr_i (clr_i),
    .flag_o(sticky_o)
  );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PW   = $clog2(WIDTH),
  localparam int unsigned HALF = WIDTH / 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [PW-1:0]    pos_i,
  input logic             clr_i,
  input logic [WIDTH-1:0] res_o,
  input logic             clamp_o,
  input logic             sticky_o
);
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] SMAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] SMIN = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] mask;
  assign mask = (ONE << pos_i) - ONE;

  p_sadd_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd1 && clamp_o) |-> res_o == (a_i[WIDTH-1] ? SMIN : SMAX));

  p_uadd_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3 && clamp_o) |-> (&res_o));

  p_usub_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4 && clamp_o) |-> res_o == '0);

  p_dbl_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd5 && clamp_o) |-> res_o == (a_i[WIDTH-1] ? SMIN : SMAX));

  p_ssat_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd6) |-> ($signed(res_o) <= $signed(mask) && $signed(res_o) >= $signed(~mask)));

  p_usat_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7) |-> res_o <= mask);

  p_usat2_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd9 && pos_i < PW'(HALF)) |->
      (res_o[HALF-1:0] <= mask[HALF-1:0] && res_o[WIDTH-1:HALF] <= mask[HALF-1:0]));

  p_wrap_sum_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0) |-> res_o == a_i + b_i);

  p_sticky_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && clamp_o) |=> sticky_o);

  p_sticky_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(valid_i && clamp_o) && !clr_i) |=> $stable(sticky_o));

  p_sticky_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(valid_i && clamp_o)) |=> !sticky_o);

  p_undef_op_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd9) |-> (res_o == '0 && !clamp_o));
endmodule

bind sat_alu sat_alu_chk #(.WIDTH(WIDTH)) i_sat_alu_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .pos_i   (pos_i),
  .clr_i   (clr_i),
  .res_o   (res_o),
  .clamp_o (clamp_o),
  .sticky_o(sticky_o)
);

// File: tb/test_sat_alu.sv
`timescale 1ns/1ps
module test_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [4:0]  pos;
  logic        clr;
  logic [31:0] res;
  logic        clamp;
  logic        sticky;

  always #2.5 clk = ~clk;

  sat_alu i_sat_alu (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .pos_i(pos), .clr_i(clr), .res_o(res), .clamp_o(clamp), .sticky_o(sticky)
  );

  typedef struct {
    logic [31:0] r;
    logic        s;
    logic        st;
    string       tag;
    string       stag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  logic  exp_sticky = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sclip(input longint v, input int n, output logic s);
    longint hi = (64'sd1 <<< n) - 1;
    longint lo = -(64'sd1 <<< n);
    s = 1'b1;
    if (v > hi) return hi[31:0];
    if (v < lo) return lo[31:0];
    s = 1'b0;
    return v[31:0];
  endfunction

  function automatic logic [31:0] uclip(input longint v, input int n, output logic s);
    longint hi = (64'sd1 <<< n) - 1;
    s = 1'b1;
    if (v < 0) return 32'h0;
    if (v > hi) return hi[31:0];
    s = 1'b0;
    return v[31:0];
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R9";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      default: return "R13";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] n, output logic [31:0] r, output logic s);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint t;
    logic   s0, s1;
    logic [31:0] r0, r1;
    r = 32'h0;
    s = 1'b0;
    case (o)
      4'd0, 4'd1, 4'd2: begin
        t = (o == 4'd2) ? sx - sy : sx + sy;
        s = (t > 64'sh7FFFFFFF) || (t < -64'sh80000000);
        if (o != 4'd0 && s) r = x[31] ? 32'h80000000 : 32'h7FFFFFFF;
        else r = t[31:0];
      end
      4'd3: begin
        t = longint'(x) + longint'(y);
        s = t > 64'sh0FFFFFFFF;
        r = s ? 32'hFFFFFFFF : t[31:0];
      end
      4'd4: begin
        s = y > x;
        r = s ? 32'h0 : x - y;
      end
      4'd5: begin
        if (sx >= 64'sh40000000) begin r = 32'h7FFFFFFF; s = 1'b1; end
        else if (sx <= -64'sh40000000) begin r = 32'h80000000; s = 1'b1; end
        else r = {x[30:0], 1'b0};
      end
      4'd6: r = sclip(sx, int'(n), s);
      4'd7: r = uclip(sx, int'(n), s);
      4'd8, 4'd9: begin
        if (o == 4'd8) begin
          r0 = sclip(longint'($signed(x[15:0])), int'(n), s0);
          r1 = sclip(longint'($signed(x[31:16])), int'(n), s1);
        end else begin
          r0 = uclip(longint'($signed(x[15:0])), int'(n), s0);
          r1 = uclip(longint'($signed(x[31:16])), int'(n), s1);
        end
        r = {r1[15:0], r0[15:0]};
        s = s0 | s1;
      end
      default: ;
    endcase
  endtask

  task automatic go(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                    input logic [4:0] n, input logic v, input logic c);
    item_t it;
    logic [31:0] r;
    logic s;
    @(negedge clk);
    op = o; a = x; b = y; pos = n; valid = v; clr = c;
    model(o, x, y, n, r, s);
    if (v && s)  it.stag = "R10";
    else if (c)  it.stag = "R12";
    else         it.stag = "R11";
    exp_sticky = (v && s) ? 1'b1 : (c ? 1'b0 : exp_sticky);
    it.r = r; it.s = s; it.st = exp_sticky; it.tag = tag_of(o);
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; clr = 1'b0; op = 4'd0;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({it.tag, " result"}, res, it.r);
      chk({it.tag, " clamp"}, {31'b0, clamp}, {31'b0, it.s});
      chk({it.stag, " sticky"}, {31'b0, sticky}, {31'b0, it.st});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; op = 4'd0; a = '0; b = '0; pos = '0; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset", {31'b0, sticky}, 32'h0);

    // R2 signed add
    go(4'd1, 32'h7FFFFFFF, 32'h1, 5'd0, 1, 0);
    go(4'd0, 32'h1, 32'h2, 5'd0, 1, 1);              // R12 clear, R9 plain sum
    go(4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1, 0);
    go(4'd1, 32'h7FFFFFFF, 32'h80000000, 5'd0, 1, 1);
    // R3 signed subtract
    go(4'd2, 32'h80000000, 32'h1, 5'd0, 1, 0);
    go(4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1, 1);
    go(4'd2, 32'h5, 32'h7, 5'd0, 1, 1);
    // R4 unsigned
    go(4'd3, 32'hFFFFFFFF, 32'h1, 5'd0, 1, 1);
    go(4'd3, 32'h1, 32'h2, 5'd0, 1, 1);
    go(4'd4, 32'h1, 32'h2, 5'd0, 1, 1);
    go(4'd4, 32'h5, 32'h5, 5'd0, 1, 1);
    // R5 doubling boundaries
    go(4'd5, 32'h40000000, 32'h0, 5'd0, 1, 1);
    go(4'd5, 32'h3FFFFFFF, 32'h0, 5'd0, 1, 1);
    go(4'd5, 32'hC0000000, 32'h0, 5'd0, 1, 1);
    go(4'd5, 32'hC0000001, 32'h0, 5'd0, 1, 1);
    // R6 signed position
    go(4'd6, 32'h00000080, 32'h0, 5'd7, 1, 1);
    go(4'd6, 32'hFFFFFF80, 32'h0, 5'd7, 1, 1);
    go(4'd6, 32'hFFFFFF7F, 32'h0, 5'd7, 1, 1);
    go(4'd6, 32'h00000005, 32'h0, 5'd0, 1, 1);
    go(4'd6, 32'h80000000, 32'h0, 5'd31, 1, 1);
    // R7 unsigned position
    go(4'd7, 32'h00000100, 32'h0, 5'd8, 1, 1);
    go(4'd7, 32'h000000FF, 32'h0, 5'd8, 1, 1);
    go(4'd7, 32'h80000000, 32'h0, 5'd8, 1, 1);
    // R8 dual halves
    go(4'd8, 32'h0100FF00, 32'h0, 5'd7, 1, 1);
    go(4'd8, 32'h80007FFF, 32'h0, 5'd15, 1, 1);
    go(4'd9, 32'hFFFF0008, 32'h0, 5'd4, 1, 1);
    go(4'd9, 32'h00200003, 32'h0, 5'd4, 1, 1);
    // R9 wrap with overflow sets flag
    go(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1, 1);
    // R13 undefined
    go(4'd12, 32'h12345678, 32'h9, 5'd3, 1, 0);
    // R11 clamp without valid is ignored
    go(4'd0, 32'h0, 32'h0, 5'd0, 1, 1);
    go(4'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 0, 0);
    go(4'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 0, 0);
    // R12 set wins over clear
    go(4'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1, 1);
    go(4'd5, 32'h1, 32'h0, 5'd0, 1, 0);              // R11 hold at 1

    // mixed stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if ((i % 5) == 0) x = {x[31], {8{x[30]}}, x[22:0]};
      go(4'($urandom_range(0, 12)), x, y, 5'($urandom_range(0, 31)),
         1'($urandom_range(0, 1)), 1'(($urandom_range(0, 3)) == 0));
    end

    // R1 asynchronous reset mid-run
    go(4'd1, 32'h7FFFFFFF, 32'h1, 5'd0, 1, 0);
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 async reset", {31'b0, sticky}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_sticky = 1'b0;
    go(4'd3, 32'h1, 32'h1, 5'd0, 1, 0);
    idle();
    repeat (3) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule